// File: doc/BRIEF.md
# Parallel ATA Device Register File and Host Strobe Front End

This block sits on the device side of a parallel ATA link running programmed I/O. It watches the two active-low chip selects, the three register address lines and the read and write strobes. It brings these host signals into the local clock domain, decodes which register is being accessed and drives the 16-bit data bus. A per-bit output enable tells the pad ring which data lines to drive. The block also holds the parameter registers that the host loads before each command, such as the transfer count, the start address and the device select.

A separate command-execution core sits behind the block. It supplies the live status bits, a completion pulse with an error code, the write-gate state and the data word for the next read. In return it receives every accepted opcode as a one-cycle pulse, every data-register access as a pulse, and the current parameter values. Interrupt handling is local to the block. A completion pulse sets the request, and the host clears it by reading the primary status location. The request line is driven only when interrupts are enabled and the device-select bit matches this unit's master or slave role.

Top module: `ata_taskfile_if`

## Requirements
- R1: Address decode: the command block is selected when `cs_cmd_n`=0 and `cs_ctl_n`=1. Its addresses for reads are 0 data, 1 error, 2 count, 3 sector, 4 cylinder low, 5 cylinder high, 6 device/head and 7 status. For writes, address 1 is feature and address 7 is command. The control block is selected when `cs_cmd_n`=1 and `cs_ctl_n`=0. Its address 6 reads alternate status and writes device control, and its address 7 reads the drive address. Any other address or chip-select combination reads with all enables low, and a write to it changes nothing.
- R2: A write takes effect when the synchronized `wr_n` returns high. Each parameter register reads back the byte written to it. The device/head register always reads with bits 7 and 5 set to 1.
- R3: A command write gives exactly one cycle of `cmd_valid` with the opcode on `cmd_code`. It clears the status ERR bit, the error register and any pending interrupt.
- R4: The status value is `core_status[7:2]` in bits 7..2, 0 in bit 1 and the local ERR flag in bit 0. On `core_done`, the error register loads `core_err` masked to bits 7, 6, 4, 2 and 0 (mask 0xD5), and ERR is set if any of those masked bits is 1.
- R5: Reading status at command-block address 7 clears the pending interrupt. Reading alternate status returns the same value and leaves the interrupt pending.
- R6: `intrq` equals the pending flag. `intrq_oe` is 1 only when device-control bit 1 is 0 and device/head bit 4 equals `role_slave`.
- R7: While `core_status[7]` (busy) is 1, every command-block write is ignored, including writes to data and command. Device-control writes are still accepted.
- R8: While device-control bit 2 is 1, `soft_reset` is 1. During that time the command-block registers, the error state and the pending flag are held at their reset values, and command-block writes have no effect.
- R9: The drive-address read drives bits 6..0 only (`dd_oe`=0x007F). Bit 6 is the inverse of `core_writing`, bits 5..2 are the inverted head number, bit 1 is the inverted device bit and bit 0 is the device bit.
- R10: Read data is loaded when the synchronized read strobe falls and stays unchanged while the strobe is held. `dd_oe` is 0xFFFF for the data register, 0x00FF for the other byte registers and 0 when no read is active.
- R11: The pending interrupt becomes set only in the cycle after a `core_done` pulse.
- R12: A data-register read returns `core_rd_word` and pulses `data_rd` once. A data-register write pulses `data_wr` once with the host word on `data_wr_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| role_slave | input | 1 | 1 when this unit is configured as slave |
| cs_cmd_n | input | 1 | Command-block chip select, active low |
| cs_ctl_n | input | 1 | Control-block chip select, active low |
| da | input | 3 | Register address |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| dd_in | input | DATA_W | Data bus from host |
| dd_out | output | DATA_W | Data bus toward host |
| dd_oe | output | DATA_W | Per-bit drive enable for dd_out |
| intrq | output | 1 | Interrupt request level |
| intrq_oe | output | 1 | Drive enable for intrq |
| core_status | input | 6 | Core status bits 7..2 (busy, ready, fault, seek done, data request, corrected) |
| core_done | input | 1 | Command completion pulse |
| core_err | input | 8 | Error code captured on core_done |
| core_writing | input | 1 | Media write gate active |
| core_rd_word | input | DATA_W | Next word for a data-register read |
| cmd_valid | output | 1 | One-cycle pulse on an accepted opcode |
| cmd_code | output | 8 | Last accepted opcode |
| data_rd | output | 1 | Pulse on a data-register read |
| data_wr | output | 1 | Pulse on a data-register write |
| data_wr_word | output | DATA_W | Word written by the host |
| tf_feature | output | 8 | Feature byte |
| tf_count | output | 8 | Transfer count byte |
| tf_sector | output | 8 | Start sector byte |
| tf_cyl | output | 16 | Cylinder high and low bytes |
| tf_devhead | output | 8 | Device/head byte |
| soft_reset | output | 1 | Software reset held by the host |

## Verification
The embedded assertions check several rules on every clock:
- The opcode pulse lasts one cycle.
- Parameter registers stay frozen while busy is high.
- Software reset empties the parameter and error state.
- A status read drops the pending request.
- A new request appears only after a completion pulse.
- The bus enables fall once the read strobe is gone.
- Read data holds still while the strobe stays low.

Other rules are visible only in the bench scenarios. These are the exact bit packing of the status, error and drive-address values, the masking of the error code and the byte-lane enables. They also include the difference between the status and alternate-status reads, the rejection of invalid chip-select pairs, and the interrupt-enable gating by mode bit and role.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int REG_W = 8;

  // byte-register field positions that the host software depends on
  localparam int ST_BSY  = 7;
  localparam int DC_SRST = 2;
  localparam int DC_NIEN = 1;
  localparam int DH_LBA  = 6;
  localparam int DH_DEV  = 4;
  localparam logic [REG_W-1:0] ERR_MASK = 8'hD5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_ERRFEAT, SEL_COUNT, SEL_SECTOR,
    SEL_CYLLO, SEL_CYLHI, SEL_DEVHEAD, SEL_STATCMD, SEL_ALTCTL, SEL_DRVADDR
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic cmd_n, input logic ctl_n,
                                          input logic [2:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (!cmd_n && ctl_n) begin
      case (a)
        3'd0: s = SEL_DATA;
        3'd1: s = SEL_ERRFEAT;
        3'd2: s = SEL_COUNT;
        3'd3: s = SEL_SECTOR;
        3'd4: s = SEL_CYLLO;
        3'd5: s = SEL_CYLHI;
        3'd6: s = SEL_DEVHEAD;
        default: s = SEL_STATCMD;
      endcase
    end else if (cmd_n && !ctl_n) begin
      if (a == 3'd6)      s = SEL_ALTCTL;
      else if (a == 3'd7) s = SEL_DRVADDR;
    end
    return s;
  endfunction
endpackage

// File: rtl/ata_strobe_sync.sv
module ata_strobe_sync
  import ata_tf_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [2:0]        da,
  input  logic [DATA_W-1:0] dd_in,
  output logic              rd_act,
  output logic              rd_start,
  output logic              wr_end,
  output reg_sel_e          sel,
  output logic [DATA_W-1:0] wdata
);
  localparam int BW = 7 + DATA_W;
  localparam logic [BW-1:0] IDLE = {4'b1111, 3'b000, {DATA_W{1'b0}}};

  logic [BW-1:0] pins;
  logic [BW-1:0] stg [STAGES];
  logic [BW-1:0] last;
  logic          rd_prev, wr_prev;

  assign pins = {rd_n, wr_n, cs_cmd_n, cs_ctl_n, da, dd_in};

  // the whole host bundle crosses through the same chain so address and data align with strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= pins;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign last = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
    end else begin
      rd_prev <= last[BW-1];
      wr_prev <= last[BW-2];
    end
  end

  assign rd_act   = !last[BW-1];
  assign rd_start = rd_prev && !last[BW-1];
  assign wr_end   = !wr_prev && last[BW-2];
  assign sel      = decode_sel(last[BW-3], last[BW-4], last[DATA_W+2:DATA_W]);
  assign wdata    = last[DATA_W-1:0];

  a_r2_write_event_single: assert property (@(posedge clk) disable iff (rst)
    wr_end |=> !wr_end);
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wbyte,
  input  logic             busy,
  input  logic             core_done,
  input  logic [REG_W-1:0] core_err,
  output logic [REG_W-1:0] feature,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] sector,
  output logic [REG_W-1:0] cyllo,
  output logic [REG_W-1:0] cylhi,
  output logic [REG_W-1:0] devhead,
  output logic             srst,
  output logic             nien,
  output logic [REG_W-1:0] err_reg,
  output logic             err_flag,
  output logic             cmd_valid,
  output logic [REG_W-1:0] cmd_code
);
  logic       dh_lba, dh_dev;
  logic [3:0] dh_head;
  logic       take;
  logic [REG_W-1:0] err_masked;

  assign take       = wr_en && !busy;
  assign err_masked = core_err & ERR_MASK;
  assign devhead    = {1'b1, dh_lba, 1'b1, dh_dev, dh_head};

  // control byte: accepted regardless of busy or reset bit so the host can always leave reset
  always_ff @(posedge clk) begin
    if (rst) begin
      srst <= 1'b0;
      nien <= 1'b0;
    end else if (wr_en && sel == SEL_ALTCTL) begin
      srst <= wbyte[DC_SRST];
      nien <= wbyte[DC_NIEN];
    end
  end

  always_ff @(posedge clk) begin
    cmd_valid <= 1'b0;
    if (rst || srst) begin
      feature  <= '0;
      count    <= '0;
      sector   <= '0;
      cyllo    <= '0;
      cylhi    <= '0;
      dh_lba   <= 1'b0;
      dh_dev   <= 1'b0;
      dh_head  <= '0;
      err_reg  <= '0;
      err_flag <= 1'b0;
      cmd_code <= '0;
    end else begin
      if (take) begin
        case (sel)
          SEL_ERRFEAT: feature <= wbyte;
          SEL_COUNT:   count   <= wbyte;
          SEL_SECTOR:  sector  <= wbyte;
          SEL_CYLLO:   cyllo   <= wbyte;
          SEL_CYLHI:   cylhi   <= wbyte;
          SEL_DEVHEAD: begin
            dh_lba  <= wbyte[DH_LBA];
            dh_dev  <= wbyte[DH_DEV];
            dh_head <= wbyte[3:0];
          end
          SEL_STATCMD: begin
            cmd_valid <= 1'b1;
            cmd_code  <= wbyte;
            err_reg   <= '0;
            err_flag  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (core_done) begin
        err_reg  <= err_masked;
        err_flag <= |err_masked;
      end
    end
  end

  a_r3_cmd_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  a_r7_busy_freezes_params: assert property (@(posedge clk) disable iff (rst)
    (busy && !srst) |=> ($stable(count) && $stable(feature) && $stable(sector)
                         && $stable(devhead) && !cmd_valid));
  a_r8_srst_empties_state: assert property (@(posedge clk) disable iff (rst)
    srst |=> (count == '0 && cyllo == '0 && cylhi == '0 && !err_flag && err_reg == '0));
endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic core_done,
  input  logic stat_rd,
  input  logic cmd_taken,
  input  logic nien,
  input  logic dev_bit,
  input  logic role_slave,
  output logic intrq,
  output logic intrq_oe
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst || srst)                pending <= 1'b0;
    else if (core_done)             pending <= 1'b1;
    else if (stat_rd || cmd_taken)  pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) intrq_oe <= 1'b0;
    else     intrq_oe <= !nien && (dev_bit == role_slave);
  end

  assign intrq = pending;

  a_r11_set_only_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(core_done));
  a_r5_status_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !core_done) |=> !pending);
  a_r6_disabled_not_driven: assert property (@(posedge clk) disable iff (rst)
    nien |=> !intrq_oe);
endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
  import ata_tf_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              role_slave,
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [2:0]        da,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] dd_out,
  output logic [DATA_W-1:0] dd_oe,
  output logic              intrq,
  output logic              intrq_oe,
  input  logic [7:2]        core_status,
  input  logic              core_done,
  input  logic [7:0]        core_err,
  input  logic              core_writing,
  input  logic [DATA_W-1:0] core_rd_word,
  output logic              cmd_valid,
  output logic [7:0]        cmd_code,
  output logic              data_rd,
  output logic              data_wr,
  output logic [DATA_W-1:0] data_wr_word,
  output logic [7:0]        tf_feature,
  output logic [7:0]        tf_count,
  output logic [7:0]        tf_sector,
  output logic [15:0]       tf_cyl,
  output logic [7:0]        tf_devhead,
  output logic              soft_reset
);
  localparam int PAD_W = DATA_W - REG_W;
  localparam logic [DATA_W-1:0] OE_WORD  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] OE_BYTE  = {{PAD_W{1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] OE_DADDR = {{PAD_W{1'b0}}, 8'h7F};

  logic              rd_act, rd_start, wr_end;
  reg_sel_e          sel;
  logic [DATA_W-1:0] wdata;
  logic [7:0]        feature, count, sector, cyllo, cylhi, devhead, err_reg;
  logic              srst, nien, err_flag;
  logic              busy;
  logic [7:0]        status_byte, drvaddr_byte;

  ata_strobe_sync #(.STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .cs_cmd_n(cs_cmd_n),
    .cs_ctl_n(cs_ctl_n), .da(da), .dd_in(dd_in), .rd_act(rd_act),
    .rd_start(rd_start), .wr_end(wr_end), .sel(sel), .wdata(wdata)
  );

  assign busy = core_status[ST_BSY];

  ata_tf_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_end), .sel(sel), .wbyte(wdata[REG_W-1:0]),
    .busy(busy), .core_done(core_done), .core_err(core_err),
    .feature(feature), .count(count), .sector(sector), .cyllo(cyllo),
    .cylhi(cylhi), .devhead(devhead), .srst(srst), .nien(nien),
    .err_reg(err_reg), .err_flag(err_flag), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code)
  );

  ata_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .srst(srst), .core_done(core_done),
    .stat_rd(rd_start && sel == SEL_STATCMD), .cmd_taken(cmd_valid),
    .nien(nien), .dev_bit(devhead[DH_DEV]), .role_slave(role_slave),
    .intrq(intrq), .intrq_oe(intrq_oe)
  );

  assign status_byte  = {core_status[7:2], 1'b0, err_flag};
  assign drvaddr_byte = {1'b0, !core_writing, ~devhead[3:0],
                         !devhead[DH_DEV], devhead[DH_DEV]};

  // read path: value captured once per strobe, then held until the strobe ends
  always_ff @(posedge clk) begin
    data_rd <= 1'b0;
    if (rst) begin
      dd_out <= '0;
      dd_oe  <= '0;
    end else if (!rd_act) begin
      dd_oe <= '0;
    end else if (rd_start) begin
      dd_oe <= OE_BYTE;
      case (sel)
        SEL_DATA: begin
          dd_out  <= core_rd_word;
          dd_oe   <= OE_WORD;
          data_rd <= 1'b1;
        end
        SEL_ERRFEAT: dd_out <= {{PAD_W{1'b0}}, err_reg};
        SEL_COUNT:   dd_out <= {{PAD_W{1'b0}}, count};
        SEL_SECTOR:  dd_out <= {{PAD_W{1'b0}}, sector};
        SEL_CYLLO:   dd_out <= {{PAD_W{1'b0}}, cyllo};
        SEL_CYLHI:   dd_out <= {{PAD_W{1'b0}}, cylhi};
        SEL_DEVHEAD: dd_out <= {{PAD_W{1'b0}}, devhead};
        SEL_STATCMD, SEL_ALTCTL: dd_out <= {{PAD_W{1'b0}}, status_byte};
        SEL_DRVADDR: begin
          dd_out <= {{PAD_W{1'b0}}, drvaddr_byte};
          dd_oe  <= OE_DADDR;
        end
        default: dd_oe <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_wr      <= 1'b0;
      data_wr_word <= '0;
    end else begin
      data_wr <= wr_end && sel == SEL_DATA && !busy && !srst;
      if (wr_end && sel == SEL_DATA) data_wr_word <= wdata;
    end
  end

  assign tf_feature = feature;
  assign tf_count   = count;
  assign tf_sector  = sector;
  assign tf_cyl     = {cylhi, cyllo};
  assign tf_devhead = devhead;
  assign soft_reset = srst;

  a_r10_release_after_strobe: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> dd_oe == '0);
  a_r10_hold_during_strobe: assert property (@(posedge clk) disable iff (rst)
    (rd_act && $past(rd_act) && !$past(rd_start)) |-> $stable(dd_out));
  a_r12_data_read_pulse: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> !data_rd);
endmodule

// File: tb/ata_taskfile_if_tb.sv
module ata_taskfile_if_tb;
  localparam int CLK_P = 10;
  localparam int DW = 16;

  logic clk = 0, rst = 1, role_slave = 0;
  logic cs_cmd_n = 1, cs_ctl_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] da = 0;
  logic [DW-1:0] dd_in = 0, dd_out, dd_oe, core_rd_word = 0, data_wr_word;
  logic intrq, intrq_oe, cmd_valid, data_rd, data_wr, soft_reset;
  logic [7:2] core_status = 6'b010100;
  logic core_done = 0, core_writing = 0;
  logic [7:0] core_err = 0, cmd_code, tf_feature, tf_count, tf_sector, tf_devhead;
  logic [15:0] tf_cyl;

  int checks = 0, errors = 0, cycles = 0;
  int n_cmd = 0, n_rd = 0, n_wr = 0;
  logic [7:0] last_code = 0;
  logic [DW-1:0] rv, ro;

  always #(CLK_P/2) clk = ~clk;

  ata_taskfile_if #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .role_slave(role_slave), .cs_cmd_n(cs_cmd_n),
    .cs_ctl_n(cs_ctl_n), .da(da), .rd_n(rd_n), .wr_n(wr_n), .dd_in(dd_in),
    .dd_out(dd_out), .dd_oe(dd_oe), .intrq(intrq), .intrq_oe(intrq_oe),
    .core_status(core_status), .core_done(core_done), .core_err(core_err),
    .core_writing(core_writing), .core_rd_word(core_rd_word),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .data_rd(data_rd),
    .data_wr(data_wr), .data_wr_word(data_wr_word), .tf_feature(tf_feature),
    .tf_count(tf_count), .tf_sector(tf_sector), .tf_cyl(tf_cyl),
    .tf_devhead(tf_devhead), .soft_reset(soft_reset)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cmd_valid) begin n_cmd <= n_cmd + 1; last_code <= cmd_code; end
    if (data_rd) n_rd <= n_rd + 1;
    if (data_wr) n_wr <= n_wr + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic cmdn, input logic ctln, input logic [2:0] a,
                        input logic [DW-1:0] d);
    @(negedge clk); cs_cmd_n = cmdn; cs_ctl_n = ctln; da = a; dd_in = d;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (5) @(negedge clk);
    cs_cmd_n = 1; cs_ctl_n = 1;
  endtask

  task automatic bus_rd(input logic cmdn, input logic ctln, input logic [2:0] a,
                        output logic [DW-1:0] v, output logic [DW-1:0] oe);
    @(negedge clk); cs_cmd_n = cmdn; cs_ctl_n = ctln; da = a;
    @(negedge clk); rd_n = 0;
    repeat (5) @(negedge clk);
    v = dd_out; oe = dd_oe;
    rd_n = 1;
    repeat (5) @(negedge clk);
    cs_cmd_n = 1; cs_ctl_n = 1;
  endtask

  task automatic wr_cmd(input logic [2:0] a, input logic [7:0] d);
    bus_wr(1'b0, 1'b1, a, {8'h00, d});
  endtask
  task automatic wr_ctl(input logic [7:0] d);
    bus_wr(1'b1, 1'b0, 3'd6, {8'h00, d});
  endtask
  task automatic rd_cmd(input logic [2:0] a);
    bus_rd(1'b0, 1'b1, a, rv, ro);
  endtask
  task automatic rd_ctl(input logic [2:0] a);
    bus_rd(1'b1, 1'b0, a, rv, ro);
  endtask

  task automatic pulse_done(input logic [7:0] e);
    @(negedge clk); core_done = 1; core_err = e;
    @(negedge clk); core_done = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R10 idle oe", dd_oe, 0);
    chk("R6 idle intrq", intrq, 0);
    chk("R6 idle intrq_oe", intrq_oe, 1);
    chk("R8 idle soft_reset", soft_reset, 0);
    chk("R2 reset devhead", tf_devhead, 8'hA0);
    chk("R3 no command at reset", n_cmd, 0);
  endtask

  task automatic t_params;
    wr_cmd(3'd2, 8'h12); wr_cmd(3'd3, 8'h34); wr_cmd(3'd4, 8'h56);
    wr_cmd(3'd5, 8'h78); wr_cmd(3'd6, 8'h0F); wr_cmd(3'd1, 8'h9A);
    rd_cmd(3'd2); chk("R2 count", rv, 16'h0012); chk("R10 byte oe", ro, 16'h00FF);
    rd_cmd(3'd3); chk("R2 sector", rv, 16'h0034);
    rd_cmd(3'd4); chk("R2 cyl low", rv, 16'h0056);
    rd_cmd(3'd5); chk("R2 cyl high", rv, 16'h0078);
    rd_cmd(3'd6); chk("R2 devhead fixed ones", rv, 16'h00AF);
    chk("R1 feature write", tf_feature, 8'h9A);
    chk("R2 cyl output", tf_cyl, 16'h7856);
  endtask

  task automatic t_data;
    core_rd_word = 16'hBEEF;
    rd_cmd(3'd0);
    chk("R12 data read", rv, 16'hBEEF); chk("R10 word oe", ro, 16'hFFFF);
    chk("R12 read pulse count", n_rd, 1);
    bus_wr(1'b0, 1'b1, 3'd0, 16'h1234);
    chk("R12 write word", data_wr_word, 16'h1234);
    chk("R12 write pulse count", n_wr, 1);
  endtask

  task automatic t_status;
    core_status = 6'b010100;
    pulse_done(8'hFF);
    chk("R11 pending after done", intrq, 1);
    rd_cmd(3'd1); chk("R4 error masked", rv, 16'h00D5);
    rd_ctl(3'd6); chk("R5 alt status value", rv, 16'h0051);
    chk("R5 alt keeps pending", intrq, 1);
    rd_cmd(3'd7); chk("R4 status value", rv, 16'h0051);
    chk("R5 status clears pending", intrq, 0);
    wr_cmd(3'd7, 8'h20);
    chk("R3 one pulse", n_cmd, 1); chk("R3 opcode", last_code, 8'h20);
    rd_cmd(3'd1); chk("R3 error cleared", rv, 16'h0000);
    rd_cmd(3'd7); chk("R3 ERR cleared", rv, 16'h0050);
  endtask

  task automatic t_irq_gate;
    pulse_done(8'h00);
    chk("R6 intrq level", intrq, 1); chk("R6 driven", intrq_oe, 1);
    wr_ctl(8'h02); chk("R6 disabled", intrq_oe, 0);
    wr_ctl(8'h00); chk("R6 re-enabled", intrq_oe, 1);
    wr_cmd(3'd6, 8'h10); chk("R6 other device", intrq_oe, 0);
    role_slave = 1; repeat (3) @(negedge clk);
    chk("R6 slave role match", intrq_oe, 1);
    role_slave = 0; wr_cmd(3'd6, 8'h00);
    rd_cmd(3'd7); chk("R5 cleared again", intrq, 0);
  endtask

  task automatic t_busy;
    core_status = 6'b100000;
    wr_cmd(3'd2, 8'h99);
    rd_cmd(3'd2); chk("R7 count frozen", rv, 16'h0012);
    wr_cmd(3'd7, 8'h30); chk("R7 command ignored", n_cmd, 1);
    bus_wr(1'b0, 1'b1, 3'd0, 16'h5555); chk("R7 data write ignored", n_wr, 1);
    wr_ctl(8'h02); chk("R7 control accepted", intrq_oe, 0);
    wr_ctl(8'h00);
    core_status = 6'b010100;
  endtask

  task automatic t_drvaddr;
    core_writing = 1; wr_cmd(3'd6, 8'h05);
    rd_ctl(3'd7); chk("R9 drive addr dev0", rv, 16'h002A); chk("R9 oe", ro, 16'h007F);
    core_writing = 0; wr_cmd(3'd6, 8'h13);
    rd_ctl(3'd7); chk("R9 drive addr dev1", rv, 16'h0071);
    wr_cmd(3'd6, 8'h00);
  endtask

  task automatic t_srst;
    wr_cmd(3'd2, 8'h44);
    pulse_done(8'h04);
    wr_ctl(8'h04);
    chk("R8 soft_reset out", soft_reset, 1);
    chk("R8 pending dropped", intrq, 0);
    wr_cmd(3'd2, 8'h55);
    rd_cmd(3'd6); chk("R8 devhead reset", rv, 16'h00A0);
    wr_ctl(8'h00);
    rd_cmd(3'd2); chk("R8 count reset", rv, 16'h0000);
    rd_cmd(3'd7); chk("R8 ERR reset", rv, 16'h0050);
  endtask

  task automatic t_decode;
    bus_wr(1'b0, 1'b0, 3'd2, 16'h0077);
    rd_cmd(3'd2); chk("R1 both selects write ignored", rv, 16'h0000);
    bus_rd(1'b0, 1'b0, 3'd2, rv, ro); chk("R1 both selects no drive", ro, 0);
    bus_rd(1'b1, 1'b1, 3'd2, rv, ro); chk("R1 no select no drive", ro, 0);
    rd_ctl(3'd3); chk("R1 reserved control addr", ro, 0);
  endtask

  task automatic t_hold;
    core_rd_word = 16'hA5A5;
    @(negedge clk); cs_cmd_n = 0; cs_ctl_n = 1; da = 0;
    @(negedge clk); rd_n = 0;
    repeat (5) @(negedge clk);
    chk("R10 first sample", dd_out, 16'hA5A5);
    core_rd_word = 16'h0F0F;
    repeat (4) @(negedge clk);
    chk("R10 held during strobe", dd_out, 16'hA5A5);
    rd_n = 1; repeat (5) @(negedge clk);
    chk("R10 released", dd_oe, 0);
    cs_cmd_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset; t_params; t_data; t_status; t_irq_gate;
    t_busy; t_drvaddr; t_srst; t_decode; t_hold;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule